// File: doc/BRIEF.md
# Per-Bank Command Timing Tracker with Internal Row Close

This block follows every bank of one 16-bank memory sub-channel. For each bank it holds an open/closed state, the open-row address and a small set of saturating down-counters. From these it tells a command scheduler, in the same cycle, whether an activate, read, write or precharge to each bank would be legal. The scheduler presents each command it issues on a single command port, with the opcode, bank and row. The tracker then updates that bank's state.

An activate to a bank that already holds a different open row is accepted. The tracker performs the row close itself, with no precharge on the command bus. The new row becomes usable only after the old row has met its minimum open time, its read or write recovery and the precharge time. Explicit precharges still work. A command that breaks a rule raises a one-cycle error pulse and leaves every bank untouched.

A query port returns, for one selected bank, whether a row is open and which row it is.

Top module: `bank_timing_tracker`

## Requirements
- R1: After synchronous reset every bank is closed. `act_ok` is all ones, `rd_ok`, `wr_ok` and `pre_ok` are all zeros, `cmd_err` is 0 and `q_open` is 0.
- R2: After an activate to a closed bank in cycle t, that bank's `rd_ok` and `wr_ok` are low through cycle t+13 and high from cycle t+14.
- R3: After an activate in cycle t, with no later read or write, that bank's `pre_ok` is low through cycle t+33 and high from cycle t+34.
- R4: A read in cycle r delays the bank's `pre_ok` until at least cycle r+4. The delay is r+6 when parameter `LONG_RTP` is 1.
- R5: A write in cycle w delays `pre_ok` until at least cycle w+22. This is 4 cycles of write latency, 2 data cycles and 16 cycles of write recovery.
- R6: A precharge in cycle p closes the bank from cycle p+1. Its `act_ok` is low through p+13 and high from p+14.
- R7: `act_ok` of an open bank is high once its activate-to-read time has elapsed. An activate with a different row is then accepted: the query port shows the new row from the next cycle. Let k be the number of cycles still left before a precharge would have been legal at the activate cycle u. Reads become legal at u+k+14+14 and precharge at u+k+14+34.
- R8: Opcodes are 0 activate, 1 read, 2 write, 3 precharge. A command whose bank flag for that opcode is low is illegal, and so is an activate that names the row already open. An illegal command gives `cmd_err` high for exactly the next cycle and changes no bank state.
- R9: `q_open` and `q_row` show the state of bank `q_bank` in the same cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 2 | Opcode: 0 act, 1 read, 2 write, 3 precharge |
| cmd_bank | input | 4 | Target bank |
| cmd_row | input | 14 | Row for activate |
| q_bank | input | 4 | Bank selected for the query port |
| act_ok | output | 16 | Per-bank activate legal |
| rd_ok | output | 16 | Per-bank read legal |
| wr_ok | output | 16 | Per-bank write legal |
| pre_ok | output | 16 | Per-bank precharge legal |
| q_open | output | 1 | Queried bank has an open row |
| q_row | output | 14 | Open row of queried bank |
| cmd_err | output | 1 | Previous cycle's command was illegal |

## Verification
Each counter is loaded at the edge that captures a command, so a gap of N cycles appears as a flag rising N cycles after the command's cycle. The error pulse and the open-row change appear one cycle after the command. The bench counts these cycles explicitly. For every timing rule it samples the flag once in the last cycle it must still be low and once in the first cycle it must be high. All samples are taken one time unit after a rising edge, and commands are driven on the falling edge, so each sample is fixed to a known cycle.

// File: rtl/btt_pkg.sv
package btt_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } op_e;

    // Width needed to hold values 0..v
    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/btt_bank_slot.sv
module btt_bank_slot
    import btt_pkg::*;
#(
    parameter int ROW_W   = 14,
    parameter int T_RCD   = 14,
    parameter int T_RP    = 14,
    parameter int T_RAS   = 34,
    parameter int T_RTP   = 4,
    parameter int T_WREC  = 22,
    parameter int CW      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             apply_i,
    input  op_e              op_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             act_ok,
    output logic             rd_ok,
    output logic             wr_ok,
    output logic             pre_ok,
    output logic             open_q,
    output logic [ROW_W-1:0] row_q
);
    localparam logic [CW-1:0] L_RCD  = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_RAS  = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_RP   = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_RTP  = CW'(T_RTP - 1);
    localparam logic [CW-1:0] L_WREC = CW'(T_WREC - 1);
    localparam logic [CW-1:0] A_RCD  = CW'(T_RP + T_RCD - 1);
    localparam logic [CW-1:0] A_RAS  = CW'(T_RP + T_RAS - 1);

    logic [CW-1:0] rcd_q, pre_q, rp_q;
    logic [CW-1:0] rcd_dec, pre_dec, rp_dec;

    assign rcd_dec = (rcd_q == '0) ? '0 : rcd_q - 1'b1;
    assign pre_dec = (pre_q == '0) ? '0 : pre_q - 1'b1;
    assign rp_dec  = (rp_q  == '0) ? '0 : rp_q  - 1'b1;

    assign act_ok = open_q ? (rcd_q == '0) : (rp_q == '0);
    assign rd_ok  = open_q && (rcd_q == '0);
    assign wr_ok  = open_q && (rcd_q == '0);
    assign pre_ok = open_q && (pre_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
            rcd_q  <= '0;
            pre_q  <= '0;
            rp_q   <= '0;
        end else begin
            rcd_q <= rcd_dec;
            pre_q <= pre_dec;
            rp_q  <= rp_dec;
            if (apply_i) begin
                unique case (op_i)
                    OP_ACT: begin
                        row_q <= row_i;
                        if (open_q) begin
                            // internal close: old row's remaining wait, then precharge
                            rcd_q <= pre_q + A_RCD;
                            pre_q <= pre_q + A_RAS;
                        end else begin
                            open_q <= 1'b1;
                            rcd_q  <= L_RCD;
                            pre_q  <= L_RAS;
                        end
                    end
                    OP_RD:  pre_q <= (pre_dec > L_RTP)  ? pre_dec : L_RTP;
                    OP_WR:  pre_q <= (pre_dec > L_WREC) ? pre_dec : L_WREC;
                    OP_PRE: begin
                        open_q <= 1'b0;
                        rp_q   <= L_RP;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    act_rcd_chk: assert property (@(posedge clk) disable iff (rst)
        (apply_i && op_i == OP_ACT) |=> (!rd_ok && !wr_ok));
    // R3
    act_ras_chk: assert property (@(posedge clk) disable iff (rst)
        (apply_i && op_i == OP_ACT) |=> !pre_ok);
    // R6
    pre_close_chk: assert property (@(posedge clk) disable iff (rst)
        (apply_i && op_i == OP_PRE) |=> (!open_q && !act_ok));
    // R7
    act_row_chk: assert property (@(posedge clk) disable iff (rst)
        (apply_i && op_i == OP_ACT) |=> (open_q && row_q == $past(row_i)));
    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (apply_i && op_i == OP_RD) |=> (open_q && !pre_ok));

endmodule

// File: rtl/btt_cmd_check.sv
module btt_cmd_check
    import btt_pkg::*;
#(
    parameter int NB     = 16,
    parameter int ROW_W  = 14,
    parameter int BANK_W = 4
) (
    input  logic                      cmd_valid,
    input  op_e                       op,
    input  logic [BANK_W-1:0]         bank,
    input  logic [ROW_W-1:0]          row,
    input  logic [NB-1:0]             act_ok,
    input  logic [NB-1:0]             rd_ok,
    input  logic [NB-1:0]             wr_ok,
    input  logic [NB-1:0]             pre_ok,
    input  logic [NB-1:0]             open_v,
    input  logic [NB-1:0][ROW_W-1:0]  rows,
    output logic [NB-1:0]             apply,
    output logic                      illegal
);
    logic legal;

    always_comb begin
        unique case (op)
            OP_ACT:  legal = act_ok[bank] && !(open_v[bank] && rows[bank] == row);
            OP_RD:   legal = rd_ok[bank];
            OP_WR:   legal = wr_ok[bank];
            OP_PRE:  legal = pre_ok[bank];
            default: legal = 1'b0;
        endcase
    end

    always_comb begin
        apply = '0;
        if (cmd_valid && legal) apply[bank] = 1'b1;
    end

    assign illegal = cmd_valid && !legal;

endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
    import btt_pkg::*;
#(
    parameter int NB       = 16,
    parameter int ROW_W    = 14,
    parameter int T_RCD    = 14,
    parameter int T_RP     = 14,
    parameter int T_RAS    = 34,
    parameter int T_WL     = 4,
    parameter int T_BURST  = 2,
    parameter int T_WR     = 16,
    parameter int T_RTP_S  = 4,
    parameter int T_RTP_L  = 6,
    parameter bit LONG_RTP = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_op,
    input  logic [$clog2(NB)-1:0]       cmd_bank,
    input  logic [ROW_W-1:0]            cmd_row,
    input  logic [$clog2(NB)-1:0]       q_bank,
    output logic [NB-1:0]               act_ok,
    output logic [NB-1:0]               rd_ok,
    output logic [NB-1:0]               wr_ok,
    output logic [NB-1:0]               pre_ok,
    output logic                        q_open,
    output logic [ROW_W-1:0]            q_row,
    output logic                        cmd_err
);
    localparam int BANK_W = $clog2(NB);
    localparam int T_RTP  = LONG_RTP ? T_RTP_L : T_RTP_S;
    localparam int T_WREC = T_WL + T_BURST + T_WR;
    localparam int PEAK   = imax(imax(T_RAS, T_WREC), T_RTP) + T_RP + T_RAS + T_RCD;
    localparam int CW     = bits_for(PEAK);

    op_e                      op;
    logic [NB-1:0]            apply;
    logic [NB-1:0]            open_v;
    logic [NB-1:0][ROW_W-1:0] rows;
    logic                     illegal;

    assign op = op_e'(cmd_op);

    btt_cmd_check #(.NB(NB), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_check (
        .cmd_valid (cmd_valid),
        .op        (op),
        .bank      (cmd_bank),
        .row       (cmd_row),
        .act_ok    (act_ok),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .pre_ok    (pre_ok),
        .open_v    (open_v),
        .rows      (rows),
        .apply     (apply),
        .illegal   (illegal)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        btt_bank_slot #(
            .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
            .T_RTP(T_RTP), .T_WREC(T_WREC), .CW(CW)
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .apply_i (apply[b]),
            .op_i    (op),
            .row_i   (cmd_row),
            .act_ok  (act_ok[b]),
            .rd_ok   (rd_ok[b]),
            .wr_ok   (wr_ok[b]),
            .pre_ok  (pre_ok[b]),
            .open_q  (open_v[b]),
            .row_q   (rows[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_err <= 1'b0;
        else     cmd_err <= illegal;
    end

    assign q_open = open_v[q_bank];
    assign q_row  = rows[q_bank];

    // R8
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(cmd_valid));
    // R8
    err_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && illegal) |=> ($stable(open_v) && $stable(rows)));
    // R8
    one_apply_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(apply));

endmodule

// File: tb/tb_bank_timing_tracker.sv
module tb_bank_timing_tracker;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [3:0]  cmd_bank;
    logic [13:0] cmd_row;
    logic [3:0]  q_bank;
    logic [15:0] act_ok, rd_ok, wr_ok, pre_ok;
    logic        q_open;
    logic [13:0] q_row;
    logic        cmd_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bank_timing_tracker dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .q_bank(q_bank),
        .act_ok(act_ok), .rd_ok(rd_ok), .wr_ok(wr_ok), .pre_ok(pre_ok),
        .q_open(q_open), .q_row(q_row), .cmd_err(cmd_err)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // Command in the current cycle t; returns at edge(t)+1, i.e. in cycle t+1
    task automatic issue(input logic [1:0] op, input logic [3:0] bank, input logic [13:0] row);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank; cmd_row = row;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        // R1
        chk("R1 act_ok", 32'(act_ok), 32'hFFFF);
        chk("R1 rd_ok",  32'(rd_ok),  32'h0);
        chk("R1 wr_ok",  32'(wr_ok),  32'h0);
        chk("R1 pre_ok", 32'(pre_ok), 32'h0);
        chk("R1 err",    32'(cmd_err), 32'h0);
        chk("R1 q_open", 32'(q_open), 32'h0);
    endtask

    task automatic t_act_pre;
        q_bank = 4'd3;
        issue(2'd0, 4'd3, 14'h0123);              // t
        chk("R9 q_open", 32'(q_open), 32'h1);
        chk("R9 q_row",  32'(q_row),  32'h0123);
        step(12);                                  // t+13
        chk("R2 rd low",  32'(rd_ok[3]), 32'h0);
        chk("R2 wr low",  32'(wr_ok[3]), 32'h0);
        step(1);                                   // t+14
        chk("R2 rd high", 32'(rd_ok[3]), 32'h1);
        chk("R2 wr high", 32'(wr_ok[3]), 32'h1);
        step(19);                                  // t+33
        chk("R3 pre low",  32'(pre_ok[3]), 32'h0);
        step(1);                                   // t+34
        chk("R3 pre high", 32'(pre_ok[3]), 32'h1);
        issue(2'd3, 4'd3, 14'h0);                  // p
        chk("R6 closed",  32'(q_open),    32'h0);
        chk("R6 act low", 32'(act_ok[3]), 32'h0);
        issue(2'd0, 4'd3, 14'h0077);               // p+1, illegal (precharge time)
        chk("R8 err early act", 32'(cmd_err), 32'h1);
        chk("R8 still closed",  32'(q_open),  32'h0);
        step(11);                                  // p+13
        chk("R6 act p+13", 32'(act_ok[3]), 32'h0);
        step(1);                                   // p+14
        chk("R6 act p+14", 32'(act_ok[3]), 32'h1);
    endtask

    task automatic t_read;
        issue(2'd0, 4'd1, 14'h0010);               // t
        step(30);                                  // t+31
        issue(2'd1, 4'd1, 14'h0);                  // r = t+31
        step(2);                                   // r+3
        chk("R4 pre low",  32'(pre_ok[1]), 32'h0);
        step(1);                                   // r+4
        chk("R4 pre high", 32'(pre_ok[1]), 32'h1);
    endtask

    task automatic t_write;
        issue(2'd0, 4'd2, 14'h0020);               // t
        step(13);                                  // t+14
        issue(2'd2, 4'd2, 14'h0);                  // w
        step(20);                                  // w+21
        chk("R5 pre low",  32'(pre_ok[2]), 32'h0);
        step(1);                                   // w+22
        chk("R5 pre high", 32'(pre_ok[2]), 32'h1);
    endtask

    task automatic t_implicit;
        q_bank = 4'd4;
        issue(2'd0, 4'd4, 14'h00AA);               // t
        step(19);                                  // t+20, k = 14
        chk("R7 act_ok open", 32'(act_ok[4]), 32'h1);
        issue(2'd0, 4'd4, 14'h0155);               // u
        chk("R7 accepted", 32'(cmd_err), 32'h0);
        chk("R7 new row",  32'(q_row),   32'h0155);
        chk("R7 open",     32'(q_open),  32'h1);
        issue(2'd1, 4'd4, 14'h0);                  // u+1, too early
        chk("R8 err early rd", 32'(cmd_err), 32'h1);
        step(39);                                  // u+41
        chk("R7 rd low",  32'(rd_ok[4]), 32'h0);
        step(1);                                   // u+42
        chk("R7 rd high", 32'(rd_ok[4]), 32'h1);
        step(19);                                  // u+61
        chk("R7 pre low",  32'(pre_ok[4]), 32'h0);
        step(1);                                   // u+62
        chk("R7 pre high", 32'(pre_ok[4]), 32'h1);
    endtask

    task automatic t_illegal;
        q_bank = 4'd4;
        issue(2'd0, 4'd4, 14'h0155);               // same row
        chk("R8 err same row", 32'(cmd_err), 32'h1);
        chk("R8 row kept",     32'(q_row),   32'h0155);
        chk("R8 pre kept",     32'(pre_ok[4]), 32'h1);
        step(1);
        chk("R8 err one cycle", 32'(cmd_err), 32'h0);
        q_bank = 4'd5;
        issue(2'd3, 4'd5, 14'h0);                  // precharge closed bank
        chk("R8 err pre idle", 32'(cmd_err), 32'h1);
        issue(2'd1, 4'd5, 14'h0);                  // read closed bank
        chk("R8 err rd idle",  32'(cmd_err), 32'h1);
        chk("R8 bank5 closed", 32'(q_open),  32'h0);
        chk("R8 bank5 act",    32'(act_ok[5]), 32'h1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_bank = 4'd0;
        cmd_row = 14'h0; q_bank = 4'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_act_pre;
        t_read;
        t_write;
        t_implicit;
        t_illegal;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule